// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status byte that a byte-wide NOR flash returns while an internal program or erase runs in the background. A command decoder (outside this block) reports the current operation mode, the data bit 7 being written, whether the current read targets the sector being erased or suspended, and a timing-limit event. From these the block produces the polling bit, two independent toggle bits, a sticky time-out flag and the erase-window flag. Software reads them to tell program from erase, to spot a suspended erase, and to find which sector is busy.

Each toggle bit is a flip-flop that inverts after every read strobe for which its toggle rule applies. A read strobe therefore returns the current value, and the next read returns the opposite value. Status outputs are combinational from the registered state and the current inputs.

The block also holds the timer for the sector-erase command window. The window opens when the first sector-erase sequence completes. While the window is open, the erase-window flag reads 0 and more sector-erase commands are accepted, and each accepted command restarts the window. When the window expires the flag reads 1, and later sector-erase commands are refused.

Top module: `flash_status_gen`

## Requirements
- R1: In program mode (mode_i=1) a valid status read returns bit 7 as the inverse of prog_d7_i and bit 2 as 1.
- R2: Bit 6 inverts after every read strobe in program (1), erase (2) and suspend-program (4) modes. Without a read strobe it holds, and in suspend-read mode (3) it neither toggles nor is shown.
- R3: In erase mode (mode_i=2) bit 7 reads 0. Bit 2 inverts after a read strobe only when sector_hit_i=1, and otherwise holds.
- R4: In suspend-read mode (mode_i=3) with sector_hit_i=1, bits 7 and 6 read 1 and bit 2 inverts after each read strobe. With sector_hit_i=0, status_valid_o is 0 and the status byte is 0x00.
- R5: In suspend-program mode (mode_i=4) bit 7 reads the inverse of prog_d7_i, bit 6 toggles per R2, and bit 2 reads 1.
- R6: limit_exceeded_i in any non-idle mode sets bit 5 from the next cycle on. Only reset clears it, and bit 6 keeps toggling after it is set.
- R7: After erase_start_i in erase mode, bit 3 reads 0 for exactly WIN_CYCLES cycles and then reads 1. Bit 3 shows the window flag in modes 2, 3 and 4 and reads 0 in program mode.
- R8: erase_accept_o is 1 for erase_cmd_i only while the window is open, and an accepted command reloads the full window. After expiry erase_cmd_i is refused and the window does not reopen.
- R9: In idle mode (mode_i=0) status_valid_o is 0 and status_o is 0x00, and the window is discarded.
- R10: Bits 1, 0 and 4 of status_o always read 0.
- R11: Asynchronous reset (rst_n low) clears both toggle bits to 0, clears bit 5 and closes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Operation mode: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program |
| rd_strobe_i | input | 1 | One status read in this cycle |
| sector_hit_i | input | 1 | Read targets the erasing or suspended sector |
| prog_d7_i | input | 1 | Bit 7 of the byte being programmed |
| limit_exceeded_i | input | 1 | Internal operation exceeded its time limit |
| erase_start_i | input | 1 | First sector-erase sequence completed |
| erase_cmd_i | input | 1 | Additional sector-erase command offered |
| erase_accept_o | output | 1 | Additional command accepted this cycle |
| status_o | output | 8 | Status byte |
| status_valid_o | output | 1 | Status byte is driven |

## Verification
Program and suspend-program reads run with prog_d7_i at both values, back-to-back and with gaps between them. This shows that the polling bit follows the data and that the toggle advances only on real strobes. Erase and suspend-read reads alternate sector_hit_i, so the bit 2 toggle rule is told apart from the bit 6 rule. Extra erase commands arrive early in the window, on its last open cycle and after it closes, which separates restart, acceptance and refusal. A limit event and a mid-run reset show that bit 5 is sticky.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_PROG      = 3'd1,
    MODE_ERASE     = 3'd2,
    MODE_SUSP_RD   = 3'd3,
    MODE_SUSP_PROG = 3'd4
  } op_mode_e;

  localparam int unsigned NUM_TOGGLES = 2;
  localparam int unsigned TOG_DQ6     = 0;
  localparam int unsigned TOG_DQ2     = 1;
endpackage

// File: rtl/flash_toggle_bit.sv
module flash_toggle_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_en,
  output logic q
);
  logic q_next;

  always_comb begin
    q_next = q;
    if (flip_en) q_next = ~q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end
endmodule

// File: rtl/flash_erase_window.sv
module flash_erase_window #(
  parameter int unsigned WIN_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic start_i,
  input  logic cmd_i,
  output logic accept_o,
  output logic closed_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_w;

  assign open_w   = armed_q && (cnt_q != '0);
  assign accept_o = cmd_i && open_w;
  assign closed_o = armed_q && (cnt_q == '0);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (clear_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (start_i) begin
      armed_d = 1'b1;
      cnt_d   = CNT_LOAD;
    end else if (accept_o) begin
      cnt_d   = CNT_LOAD;
    end else if (open_w) begin
      cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R8: an accepted command leaves the window open on the next cycle
  assert_accept_reopens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !clear_i && !start_i) |=> (armed_q && cnt_q == CNT_LOAD));

  // R7: once closed, the window stays closed until cleared or restarted
  assert_closed_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (closed_o && !clear_i && !start_i) |=> closed_o);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       rd_strobe_i,
  input  logic       sector_hit_i,
  input  logic       prog_d7_i,
  input  logic       limit_exceeded_i,
  input  logic       erase_start_i,
  input  logic       erase_cmd_i,
  output logic       erase_accept_o,
  output logic [7:0] status_o,
  output logic       status_valid_o
);
  op_mode_e mode;
  assign mode = op_mode_e'(mode_i);

  logic [NUM_TOGGLES-1:0] tog_en;
  logic [NUM_TOGGLES-1:0] tog_q;
  logic is_prog_like, is_erase_like, active;
  logic dq5_q, dq5_d;
  logic win_closed;

  assign is_prog_like  = (mode == MODE_PROG) || (mode == MODE_SUSP_PROG);
  assign is_erase_like = (mode == MODE_ERASE) || (mode == MODE_SUSP_RD) ||
                         (mode == MODE_SUSP_PROG);
  assign active        = (mode != MODE_IDLE);

  always_comb begin
    tog_en[TOG_DQ6] = rd_strobe_i && (is_prog_like || mode == MODE_ERASE);
    tog_en[TOG_DQ2] = rd_strobe_i && sector_hit_i &&
                      (mode == MODE_ERASE || mode == MODE_SUSP_RD);
  end

  for (genvar g = 0; g < NUM_TOGGLES; g++) begin : g_tog
    flash_toggle_bit u_tog (
      .clk     (clk),
      .rst_n   (rst_n),
      .flip_en (tog_en[g]),
      .q       (tog_q[g])
    );
  end

  flash_erase_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (mode == MODE_IDLE),
    .start_i  (erase_start_i && mode == MODE_ERASE),
    .cmd_i    (erase_cmd_i),
    .accept_o (erase_accept_o),
    .closed_o (win_closed)
  );

  always_comb begin
    dq5_d = dq5_q;
    if (limit_exceeded_i && active) dq5_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dq5_q <= 1'b0;
    else        dq5_q <= dq5_d;
  end

  always_comb begin
    status_valid_o = active && !(mode == MODE_SUSP_RD && !sector_hit_i);
    status_o       = 8'h00;
    if (status_valid_o) begin
      unique case (mode)
        MODE_PROG, MODE_SUSP_PROG: begin
          status_o[7] = ~prog_d7_i;
          status_o[6] = tog_q[TOG_DQ6];
          status_o[2] = 1'b1;
        end
        MODE_ERASE: begin
          status_o[7] = 1'b0;
          status_o[6] = tog_q[TOG_DQ6];
          status_o[2] = tog_q[TOG_DQ2];
        end
        MODE_SUSP_RD: begin
          status_o[7] = 1'b1;
          status_o[6] = 1'b1;
          status_o[2] = tog_q[TOG_DQ2];
        end
        default: status_o = 8'h00;
      endcase
      status_o[5] = dq5_q;
      status_o[3] = is_erase_like && win_closed;
    end
  end

  // R2: a read strobe in program mode flips the bit 6 toggle
  assert_dq6_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe_i && mode == MODE_PROG) |=> (tog_q[TOG_DQ6] != $past(tog_q[TOG_DQ6])));

  // R3: an erase read outside the erasing sector leaves bit 2 alone
  assert_dq2_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ERASE && !sector_hit_i) |=> $stable(tog_q[TOG_DQ2]));

  // R6: the time-out flag never drops without reset
  assert_dq5_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq5_q |=> dq5_q);

  // R9: an undriven status byte reads zero
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !status_valid_o |-> (status_o == 8'h00));

  // R10: unused bit positions stay zero
  assert_unused_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] == 1'b0) && (status_o[1:0] == 2'b00));

  // R4: suspend-read reads from the suspended sector return bits 7 and 6 high
  assert_susp_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SUSP_RD && sector_hit_i) |-> (status_o[7:6] == 2'b11));
endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic rd_strobe_i = 1'b0, sector_hit_i = 1'b0, prog_d7_i = 1'b0;
  logic limit_exceeded_i = 1'b0, erase_start_i = 1'b0, erase_cmd_i = 1'b0;
  logic erase_accept_o, status_valid_o;
  logic [7:0] status_o;

  int n_checks = 0;
  int n_fail = 0;

  int m_t6, m_t2, m_dq5, m_armed, m_cnt;

  always #4 clk = ~clk;

  flash_status_gen #(.WIN_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rd_strobe_i(rd_strobe_i),
    .sector_hit_i(sector_hit_i), .prog_d7_i(prog_d7_i),
    .limit_exceeded_i(limit_exceeded_i), .erase_start_i(erase_start_i),
    .erase_cmd_i(erase_cmd_i), .erase_accept_o(erase_accept_o),
    .status_o(status_o), .status_valid_o(status_valid_o)
  );

  function automatic string tag_of(input int m);
    case (m)
      0: return "R9";
      1: return "R1";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic model_reset();
    m_t6 = 0; m_t2 = 0; m_dq5 = 0; m_armed = 0; m_cnt = 0;
  endtask

  task automatic compare(input string tag);
    int m;
    bit vld, acc;
    logic [7:0] exp;
    m   = int'(mode_i);
    vld = (m != 0) && !(m == 3 && !sector_hit_i);
    exp = 8'h00;
    if (vld) begin
      case (m)
        1, 4: begin exp[7] = ~prog_d7_i; exp[6] = m_t6[0]; exp[2] = 1'b1; end
        2:    begin exp[7] = 1'b0;       exp[6] = m_t6[0]; exp[2] = m_t2[0]; end
        default: begin exp[7] = 1'b1;    exp[6] = 1'b1;    exp[2] = m_t2[0]; end
      endcase
      exp[5] = m_dq5[0];
      exp[3] = (m >= 2) && m_armed != 0 && m_cnt == 0;
    end
    acc = erase_cmd_i && m_armed != 0 && m_cnt != 0;
    n_checks++;
    if (status_valid_o !== vld) begin
      n_fail++;
      $display("FAIL %s valid: actual %0b expected %0b", tag, status_valid_o, vld);
    end
    n_checks++;
    if (status_o !== exp) begin
      n_fail++;
      $display("FAIL %s status: actual %02h expected %02h", tag, status_o, exp);
    end
    n_checks++;
    if (erase_accept_o !== acc) begin
      n_fail++;
      $display("FAIL R8 accept: actual %0b expected %0b", erase_accept_o, acc);
    end
  endtask

  task automatic model_clock();
    int m;
    bit acc;
    m   = int'(mode_i);
    acc = erase_cmd_i && m_armed != 0 && m_cnt != 0;
    if (rd_strobe_i && (m == 1 || m == 2 || m == 4)) m_t6 ^= 1;
    if (rd_strobe_i && sector_hit_i && (m == 2 || m == 3)) m_t2 ^= 1;
    if (limit_exceeded_i && m != 0) m_dq5 = 1;
    if (m == 0) begin m_armed = 0; m_cnt = 0; end
    else if (erase_start_i && m == 2) begin m_armed = 1; m_cnt = W; end
    else if (acc) m_cnt = W;
    else if (m_armed != 0 && m_cnt != 0) m_cnt--;
  endtask

  // one cycle: inputs were set at the negedge; compare, then clock the model
  task automatic step(input string tag);
    #1 compare(tag);
    @(posedge clk);
    model_clock();
    @(negedge clk);
    rd_strobe_i = 0; erase_start_i = 0; erase_cmd_i = 0; limit_exceeded_i = 0;
  endtask

  task automatic rd(input int m, input bit hit, input bit d7);
    mode_i = 3'(m); sector_hit_i = hit; prog_d7_i = d7; rd_strobe_i = 1;
    step(tag_of(m));
  endtask

  task automatic idle_cyc(input int m);
    mode_i = 3'(m);
    step(tag_of(m));
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    compare("R11");                        // reset state, R11
    @(negedge clk);
    rst_n = 1;
    idle_cyc(0); idle_cyc(0);              // R9 idle, R10
    // R1 / R2: program reads with both data values and gaps
    rd(1, 0, 0); rd(1, 0, 1); rd(1, 1, 1); idle_cyc(1); idle_cyc(1); rd(1, 0, 0);
    // R3: erase reads, alternating sector hit
    rd(2, 1, 0); rd(2, 0, 0); rd(2, 1, 0); rd(2, 1, 0); rd(2, 0, 0); idle_cyc(2);
    // R7 / R8: window start, early extra command, last-open-cycle command
    mode_i = 3'd2; erase_start_i = 1; step("R7");
    idle_cyc(2); idle_cyc(2);
    erase_cmd_i = 1; step("R8");
    for (int i = 0; i < W - 1; i++) idle_cyc(2);
    erase_cmd_i = 1; step("R8");           // last open cycle: accepted, restarts
    for (int i = 0; i < W + 2; i++) idle_cyc(2);
    erase_cmd_i = 1; step("R8");           // after expiry: refused
    idle_cyc(2);
    // R4: suspend-read, hit and non-hit reads
    rd(3, 1, 0); rd(3, 1, 0); rd(3, 0, 0); rd(3, 1, 1); idle_cyc(3);
    // R5: suspend-program
    rd(4, 0, 1); rd(4, 1, 0); rd(4, 0, 0); idle_cyc(4);
    // R9: idle discards the window
    idle_cyc(0); idle_cyc(2);
    // R6: limit in program mode, toggling continues, flag sticky
    rd(1, 0, 1); mode_i = 3'd1; limit_exceeded_i = 1; step("R6");
    rd(1, 0, 1); rd(1, 0, 1); idle_cyc(0); rd(2, 1, 0);
    limit_exceeded_i = 1; idle_cyc(0);     // limit in idle ignored, R6
    // R11: reset mid-run clears flag, toggles and window
    mode_i = 3'd2; erase_start_i = 1; step("R7");
    rst_n = 0; model_reset(); #1 compare("R11");
    @(posedge clk); @(negedge clk); rst_n = 1;
    rd(2, 1, 0); rd(1, 0, 0); idle_cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule